// File: doc/BRIEF.md
# Hourly Strike-Count Chime Sequencer

This block strikes the hour in 12-hour form. A register holds the hour to be struck. Each hourly request advances that register and, one cycle later, copies it into a down counter. The down counter then releases one strike pulse per one-second tick until it is empty. While a sequence is running, its remaining count is shown as two BCD digits for indicator lamps.

Three sources can request a sequence. The first is the hourly pulse. The second is a manual-advance button, debounced inside the block, which steps the hour by one each time it is pressed. The third is a midnight pulse. The midnight pulse is re-timed through two stages clocked by the second tick, and it then forces the hour to twelve, so that drift picked up during the day is removed and twelve strikes follow.

A chime-enable switch stops the strike pulses without stopping the count, and a chime-off indicator follows that switch. All inputs are sampled on the system clock, and `sec_tick` is a one-cycle pulse.

Top module: `chime_sequencer`

## Requirements
- R1: After reset, `remain_bcd` is 0, `strike` is 0 and the held hour is 12, so the first hourly request strikes once.
- R2: An hourly pulse that arrives while no sequence is running advances the held hour, and within four clock cycles `remain_bcd` shows the new hour.
- R3: The held hour advances from 12 back to 1, so every sequence strikes between 1 and 12 times.
- R4: On each `sec_tick` while the remaining count is nonzero, the count drops by one, and `strike` is high for exactly the following cycle.
- R5: When the remaining count is zero, or no tick is present, the count holds and `strike` stays low.
- R6: `remain_bcd[4]` is the tens digit (0 or 1) and `remain_bcd[3:0]` is the units digit (0 to 9) of the remaining count.
- R7: A high level on `advance_btn` is taken as one press only after it has been stable for `DEBOUNCE_CYC` clock cycles after synchronisation. A shorter pulse is ignored.
- R8: A press acts like an hourly pulse: it advances the hour by one and strikes the new hour.
- R9: A request that arrives while a sequence is running is held and starts once the count reaches zero. Further requests that arrive while one is already held merge into it.
- R10: After a midnight pulse, the second following `sec_tick` forces the hour to 12 and starts a twelve-strike sequence; this takes precedence over a held hourly request. An hourly pulse in the same cycle as the midnight pulse is dropped. The next hourly request then strikes 1.
- R11: While `chime_en` is low, `strike` stays low but the count still runs, and `chime_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hour_pulse | input | 1 | One-cycle hourly request |
| midnight_pulse | input | 1 | One-cycle midnight re-synchronisation request |
| sec_tick | input | 1 | One-cycle pulse once per second; paces the strikes |
| advance_btn | input | 1 | Raw manual-advance button level |
| chime_en | input | 1 | High lets strikes reach the output |
| strike | output | 1 | One-cycle strike drive |
| remain_bcd | output | 5 | Remaining strike count in BCD, {tens, units} |
| chime_off | output | 1 | High while strikes are suppressed |

## Verification
A held hour that is wrong is not visible until the next request. At that point it appears as a wrong value on `remain_bcd` within four cycles, and as a wrong number of strikes. A broken wrap therefore shows on the request after twelve, and a broken midnight path shows two ticks after the midnight pulse. A down counter that skips or sticks shows at the first tick: `remain_bcd` misses its decrement, or `strike` appears with no count left. A lost or duplicated held request shows once the running sequence empties: either the next hour never loads, or a second sequence follows where a single merged one was expected.

// File: rtl/chime_pkg.sv
package chime_pkg;
  localparam int unsigned HOUR_MAX = 12;
  localparam int unsigned CNT_W    = $clog2(HOUR_MAX + 1);
  localparam int unsigned BCD_W    = 5;

  typedef logic [CNT_W-1:0] count_t;
  typedef logic [BCD_W-1:0] bcd_t;

  function automatic bcd_t to_bcd(count_t v);
    logic       tens;
    logic [3:0] units;
    tens  = (v >= count_t'(10));
    units = 4'(tens ? v - count_t'(10) : v);
    return {tens, units};
  endfunction

  function automatic count_t next_hour(count_t h);
    return (h >= count_t'(HOUR_MAX)) ? count_t'(1) : h + count_t'(1);
  endfunction
endpackage

// File: rtl/chime_debounce.sv
module chime_debounce #(
  parameter int unsigned STABLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int unsigned CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic          sync0_q, sync1_q, level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync0_q <= 1'b0;
      sync1_q <= 1'b0;
      level_q <= 1'b0;
      run_q   <= '0;
      press   <= 1'b0;
    end else begin
      sync0_q <= raw;
      sync1_q <= sync0_q;
      press   <= 1'b0;
      if (sync1_q != level_q) begin
        if (run_q == LAST) begin
          level_q <= sync1_q;
          run_q   <= '0;
          press   <= sync1_q;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/chime_midnight_sync.sv
module chime_midnight_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic midnight,
  input  logic tick,
  output logic fire
);
  logic arm_q, stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      stage_q <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= tick && stage_q;
      if (tick) stage_q <= arm_q;
      if (midnight)  arm_q <= 1'b1;
      else if (tick) arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/chime_strike_counter.sv
module chime_strike_counter
  import chime_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  count_t load_val,
  input  logic   tick,
  input  logic   enable,
  output logic   strike,
  output bcd_t   remain,
  output logic   idle
);
  count_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      strike <= 1'b0;
    end else begin
      strike <= tick && (cnt_q != '0) && enable;
      if (load)                         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign remain = to_bcd(cnt_q);
  assign idle   = (cnt_q == '0);
endmodule

// File: rtl/chime_sequencer.sv
module chime_sequencer
  import chime_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hour_pulse,
  input  logic       midnight_pulse,
  input  logic       sec_tick,
  input  logic       advance_btn,
  input  logic       chime_en,
  output logic       strike,
  output logic [4:0] remain_bcd,
  output logic       chime_off
);
  logic   press, sync_fire, idle;
  logic   hr_pend_q, sync_pend_q, load_q, accept, hour_req;
  count_t hr_q;

  chime_debounce #(.STABLE_CYC(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw(advance_btn), .press(press)
  );

  chime_midnight_sync u_mid (
    .clk(clk), .rst_n(rst_n), .midnight(midnight_pulse), .tick(sec_tick),
    .fire(sync_fire)
  );

  chime_strike_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_q), .load_val(hr_q),
    .tick(sec_tick), .enable(chime_en), .strike(strike),
    .remain(remain_bcd), .idle(idle)
  );

  assign hour_req = (hour_pulse && !midnight_pulse) || press;
  assign accept   = idle && !load_q && (sync_pend_q || hr_pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_q        <= count_t'(HOUR_MAX);
      hr_pend_q   <= 1'b0;
      sync_pend_q <= 1'b0;
      load_q      <= 1'b0;
    end else begin
      load_q <= accept;
      if (accept) begin
        if (sync_pend_q) begin
          hr_q        <= count_t'(HOUR_MAX);
          sync_pend_q <= 1'b0;
        end else begin
          hr_q      <= next_hour(hr_q);
          hr_pend_q <= 1'b0;
        end
      end
      if (hour_req)  hr_pend_q   <= 1'b1;
      if (sync_fire) sync_pend_q <= 1'b1;
    end
  end

  assign chime_off = !chime_en;
endmodule

// File: rtl/chime_sequencer_chk.sv
module chime_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       chime_en,
  input logic       strike,
  input logic [4:0] remain_bcd,
  input logic [3:0] hr
);
  function automatic int bval(logic [4:0] b);
    return (b[4] ? 10 : 0) + int'(b[3:0]);
  endfunction

  assert_strike_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strike |-> $past(chime_en));

  assert_strike_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strike |-> ($past(sec_tick) && ($past(remain_bcd) != 5'd0)));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && remain_bcd != 5'd0) |=> (bval(remain_bcd) == bval($past(remain_bcd)) - 1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && remain_bcd != 5'd0) |=> $stable(remain_bcd));

  assert_bcd_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_bcd[3:0] <= 4'd9) && (bval(remain_bcd) <= 12));

  assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hr >= 4'd1) && (hr <= 4'd12));
endmodule

bind chime_sequencer chime_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .chime_en(chime_en),
  .strike(strike), .remain_bcd(remain_bcd), .hr(hr_q)
);

// File: tb/chime_sequencer_test.sv
module chime_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hour_pulse = 1'b0, midnight_pulse = 1'b0, sec_tick = 1'b0;
  logic advance_btn = 1'b0, chime_en = 1'b1;
  logic strike, chime_off;
  logic [4:0] remain_bcd;

  int checks = 0, errors = 0, exp_hr = 12;
  bit finished = 0;

  chime_sequencer #(.DEBOUNCE_CYC(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .hour_pulse(hour_pulse),
    .midnight_pulse(midnight_pulse), .sec_tick(sec_tick),
    .advance_btn(advance_btn), .chime_en(chime_en), .strike(strike),
    .remain_bcd(remain_bcd), .chime_off(chime_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] bcd(int v);
    return {v >= 10, 4'(v % 10)};
  endfunction

  function automatic int nxt(int h);
    return (h >= 12) ? 1 : h + 1;
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic pulse_hour(string req);
    hour_pulse = 1'b1; @(negedge clk); hour_pulse = 1'b0;
    cyc(3);
    exp_hr = nxt(exp_hr);
    chk(remain_bcd, bcd(exp_hr), req);
  endtask

  task automatic strike_out(int n);
    for (int i = 0; i < n; i++) begin
      cyc($urandom_range(0, 3));
      tick();
      chk(strike, chime_en, "R4 strike");
      chk(remain_bcd, bcd(n - 1 - i), "R4 R6 remain");
    end
    cyc(1);
    chk(strike, 0, "R4 single-cycle strike");
  endtask

  task automatic idle_tick();
    tick();
    chk(strike, 0, "R5 idle strike");
    chk(remain_bcd, 0, "R5 idle remain");
  endtask

  initial begin
    void'($urandom(32'd2024));
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    chk(remain_bcd, 0, "R1 remain");
    chk(strike, 0, "R1 strike");
    chk(chime_off, 0, "R11 chime_off");

    pulse_hour("R1 R2 first hour");
    strike_out(exp_hr);
    idle_tick();

    for (int k = 0; k < 13; k++) begin
      int prev = exp_hr;
      chime_en = ($urandom_range(0, 3) != 0);
      cyc($urandom_range(1, 5));
      pulse_hour(prev == 12 ? "R3 wrap" : "R2 hour");
      strike_out(exp_hr);
    end

    chime_en = 1'b0;
    cyc(1);
    chk(chime_off, 1, "R11 chime_off");
    chime_en = 1'b1;
    cyc(1);

    advance_btn = 1'b1; cyc(DEB / 2); advance_btn = 1'b0;
    cyc(DEB + 10);
    chk(remain_bcd, 0, "R7 bounce ignored");

    advance_btn = 1'b1; cyc(DEB + 8); advance_btn = 1'b0;
    exp_hr = nxt(exp_hr);
    chk(remain_bcd, bcd(exp_hr), "R8 advance");
    cyc(DEB + 8);
    chk(remain_bcd, bcd(exp_hr), "R7 release no press");
    strike_out(exp_hr);

    pulse_hour("R2 before pending");
    tick();
    chk(remain_bcd, bcd(exp_hr - 1), "R9 running");
    hour_pulse = 1'b1; @(negedge clk); hour_pulse = 1'b0;
    cyc(2);
    hour_pulse = 1'b1; @(negedge clk); hour_pulse = 1'b0;
    chk(remain_bcd, bcd(exp_hr - 1), "R9 held during run");
    strike_out(exp_hr - 1);
    cyc(3);
    exp_hr = nxt(exp_hr);
    chk(remain_bcd, bcd(exp_hr), "R9 held request started");
    strike_out(exp_hr);
    cyc(4);
    chk(remain_bcd, 0, "R9 merged");

    hour_pulse = 1'b1; midnight_pulse = 1'b1; @(negedge clk);
    hour_pulse = 1'b0; midnight_pulse = 1'b0;
    cyc(4);
    chk(remain_bcd, 0, "R10 hour dropped");
    tick(); cyc(3);
    chk(remain_bcd, 0, "R10 waits second tick");
    tick(); cyc(4);
    exp_hr = 12;
    chk(remain_bcd, bcd(12), "R10 forced twelve");
    strike_out(12);
    pulse_hour("R10 after midnight");
    strike_out(exp_hr);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule